// File: doc/BRIEF.md
# Compressed Instruction Expander

This block takes a 16-bit compressed instruction and turns it into the 32-bit base-set instruction that has the same effect. It handles the integer subset of the three compressed quadrants. This covers stack-relative add, load and store, immediate arithmetic, upper-immediate load, stack adjustment, shifts, register arithmetic, jumps, branches, moves and breakpoint. The block also raises an illegal flag for encodings that are reserved, floating-point or 64-bit-only. A fetch or decode stage places it in front of a 32-bit decoder, so that the decoder only ever sees full-width words.

The expansion is purely a rearrangement of fields. The work lies in reassembling the scattered immediate bits and in telling apart the zero-field cases: some reserve the encoding, and others turn it into a harmless hint. The result is registered once. A word presented before a rising edge therefore appears at the outputs after that edge.

Top module: `c16_expander`

## Requirements
- R1: While `rst_n` is low at a rising edge, `exp_word` becomes 0 and `exp_bad` becomes 0.
- R2: The outputs change only at a rising edge and reflect the `cmp_word` value sampled at that edge, giving one cycle of latency.
- R3: A 3-bit register field selects register 8 plus the field value, covering x8 to x15.
- R4: Quadrant 0 (bits [1:0]=00) covers three forms. Funct3 000 gives addi rd', x2, uimm, where bits [10:7], [12:11], 5 and 6 supply uimm[9:6], [5:4], [3] and [2]. Funct3 010 gives lw and funct3 110 gives sw, with offset bits 5, [12:10] and 6 supplying off[6], [5:3] and [2]. A zero uimm is illegal, so the all-zero word is illegal.
- R5: Quadrant 1 funct3 000 gives addi rd, rd, simm6 and funct3 010 gives addi rd, x0, simm6, where simm6 is {bit12, bits[6:2]}. With rd=0 these forms are hints: they expand with rd=x0 and are not flagged.
- R6: Quadrant 1 funct3 011 with rd=2 gives addi x2, x2, imm, where bits 12, [4:3], 5, 2 and 6 supply imm[9], [8:7], [6], [5] and [4]. With any other nonzero rd it gives lui rd with a sign-extended {bit12, bits[6:2]} as the upper immediate. A zero immediate is illegal in both cases.
- R7: Quadrant 1 funct3 100 decodes bits [11:10]. Values 00 and 01 give srli and srai, and a set bit 12 is illegal. Value 10 gives andi. Value 11 with bit 12 clear gives sub, xor, or and and, selected by bits [6:5]=00..11. Value 11 with bit 12 set is illegal.
- R8: Quadrant 1 funct3 001 gives jal x1 and funct3 101 gives jal x0. The offset is built from bit 12 to off[11], 8 to [10], [10:9] to [9:8], 6 to [7], 7 to [6], 2 to [5], 11 to [4] and [5:3] to [3:1].
- R9: Quadrant 1 funct3 110 gives beq rs1', x0 and funct3 111 gives bne rs1', x0. The offset is built from bit 12 to off[8], [6:5] to [7:6], 2 to [5], [11:10] to [4:3] and [4:3] to [2:1].
- R10: Quadrant 2 covers three forms. Funct3 000 gives slli, and a set bit 12 is illegal. Funct3 010 gives lw rd, off(x2), with offset bits [3:2], 12 and [6:4] supplying off[7:6], [5] and [4:2], and rd=0 is illegal. Funct3 110 gives sw rs2, off(x2), with offset bits [8:7] and [12:9] supplying off[7:6] and [5:2].
- R11: Quadrant 2 funct3 100 splits on bit 12. With bit 12 clear, rs2=0 gives jalr x0, 0(rd) and rd=0 is illegal there; a nonzero rs2 gives add rd, x0, rs2. With bit 12 set, rs2=0 and rd=0 gives ebreak (0x00100073); rs2=0 with a nonzero rd gives jalr x1, 0(rd); a nonzero rs2 gives add rd, rd, rs2.
- R12: Quadrant 0 funct3 other than 000, 010 and 110 is illegal, as is quadrant 2 funct3 001, 011, 101 and 111. Whenever `exp_bad` is 1, `exp_word` is 0.
- R13: An input with bits [1:0]=11 is passed through as {16'h0000, cmp_word} with `exp_bad` clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_word | input | 16 | Compressed instruction to expand |
| exp_word | output | 32 | Expanded instruction, registered |
| exp_bad | output | 1 | Illegal or reserved encoding, registered |

## Verification
Four relations are checked by properties on every cycle: the pass-through of uncompressed words, the zero word that accompanies every illegal flag, the flag raised for the all-zero input, and the 11 in the low bits of every legal expansion. The exact field placement of each scrambled immediate cannot be shown by those properties. The same holds for the boundary between reserved and hint encodings. These appear only in the bench's vector table, whose expected words were assembled by hand from the requirements. Reset behaviour and the one-cycle latency are shown by directed bench scenarios.

// File: rtl/c16_pkg.sv
// Package c16_pkg: opcodes and field packers for the 32-bit formats.
// Assumes little-endian base encodings with 5-bit register indices.
package c16_pkg;
    localparam int CW = 16;
    localparam int XW = 32;
    localparam int RW = 5;

    typedef logic [RW-1:0] rix_t;

    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_OPIMM = 7'b0010011;
    localparam logic [6:0] OPC_STORE = 7'b0100011;
    localparam logic [6:0] OPC_OP    = 7'b0110011;
    localparam logic [6:0] OPC_LUI   = 7'b0110111;
    localparam logic [6:0] OPC_BR    = 7'b1100011;
    localparam logic [6:0] OPC_JALR  = 7'b1100111;
    localparam logic [6:0] OPC_JAL   = 7'b1101111;
    localparam logic [XW-1:0] WORD_EBREAK = 32'h0010_0073;

    localparam rix_t R_ZERO = 5'd0;
    localparam rix_t R_LINK = 5'd1;
    localparam rix_t R_SP   = 5'd2;

    // Map a 3-bit compact field onto x8..x15.
    function automatic rix_t creg(input logic [2:0] f);
        return {2'b01, f};
    endfunction

    function automatic logic [XW-1:0] fmt_i(input logic [11:0] imm, input rix_t rs1,
                                            input logic [2:0] f3, input rix_t rd,
                                            input logic [6:0] op);
        return {imm, rs1, f3, rd, op};
    endfunction

    function automatic logic [XW-1:0] fmt_s(input logic [11:0] imm, input rix_t rs2,
                                            input rix_t rs1, input logic [2:0] f3);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], OPC_STORE};
    endfunction

    function automatic logic [XW-1:0] fmt_r(input logic [6:0] f7, input rix_t rs2,
                                            input rix_t rs1, input logic [2:0] f3,
                                            input rix_t rd);
        return {f7, rs2, rs1, f3, rd, OPC_OP};
    endfunction

    function automatic logic [XW-1:0] fmt_b(input logic [12:0] imm, input rix_t rs1,
                                            input logic [2:0] f3);
        return {imm[12], imm[10:5], R_ZERO, rs1, f3, imm[4:1], imm[11], OPC_BR};
    endfunction

    function automatic logic [XW-1:0] fmt_u(input logic [19:0] imm, input rix_t rd);
        return {imm, rd, OPC_LUI};
    endfunction

    function automatic logic [XW-1:0] fmt_j(input logic [20:0] imm, input rix_t rd);
        return {imm[20], imm[10:1], imm[11], imm[19:12], rd, OPC_JAL};
    endfunction
endpackage

// File: rtl/c16_q0.sv
// c16_q0: expands quadrant-0 words (stack-pointer add, word load, word store).
// Assumes the caller has already selected quadrant 0; bits [1:0] are not seen.
module c16_q0
    import c16_pkg::*;
(
    input  logic [CW-1:2] ins,
    output logic [XW-1:0] word,
    output logic          bad
);
    logic [9:0] spu;
    logic [6:0] woff;

    // Reassemble the scrambled unsigned immediates.
    always_comb begin
        spu  = {ins[10:7], ins[12:11], ins[5], ins[6], 2'b00};
        woff = {ins[5], ins[12:10], ins[6], 2'b00};
    end

    // Choose the form by funct3 and flag reserved ones.
    always_comb begin
        word = '0;
        bad  = 1'b0;
        unique case (ins[15:13])
            3'b000: begin
                bad  = (spu == 10'd0);
                word = fmt_i({2'b00, spu}, R_SP, 3'b000, creg(ins[4:2]), OPC_OPIMM);
            end
            3'b010: word = fmt_i({5'd0, woff}, creg(ins[9:7]), 3'b010, creg(ins[4:2]), OPC_LOAD);
            3'b110: word = fmt_s({5'd0, woff}, creg(ins[4:2]), creg(ins[9:7]), 3'b010);
            default: bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/c16_q1.sv
// c16_q1: expands quadrant-1 words (immediates, stack adjust, LUI, shifts,
// register arithmetic, jumps, branches). Assumes quadrant 1 is selected.
module c16_q1
    import c16_pkg::*;
(
    input  logic [CW-1:2] ins,
    output logic [XW-1:0] word,
    output logic          bad
);
    rix_t        rd;
    rix_t        rdc;
    rix_t        rsc;
    logic [11:0] simm;
    logic [9:0]  adj;
    logic [11:0] joff;
    logic [8:0]  boff;
    logic        smallz;

    // Pull register fields and reassemble each immediate layout.
    always_comb begin
        rd     = ins[11:7];
        rdc    = creg(ins[9:7]);
        rsc    = creg(ins[4:2]);
        simm   = {{6{ins[12]}}, ins[12], ins[6:2]};
        smallz = ({ins[12], ins[6:2]} == 6'd0);
        adj    = {ins[12], ins[4:3], ins[5], ins[2], ins[6], 4'b0000};
        joff   = {ins[12], ins[8], ins[10:9], ins[6], ins[7], ins[2], ins[11], ins[5:3], 1'b0};
        boff   = {ins[12], ins[6:5], ins[2], ins[11:10], ins[4:3], 1'b0};
    end

    // Select the form by funct3 and the sub-fields below it.
    always_comb begin
        word = '0;
        bad  = 1'b0;
        unique case (ins[15:13])
            3'b000: word = fmt_i(simm, rd, 3'b000, rd, OPC_OPIMM);
            3'b001: word = fmt_j({{9{ins[12]}}, joff}, R_LINK);
            3'b010: word = fmt_i(simm, R_ZERO, 3'b000, rd, OPC_OPIMM);
            3'b011: begin
                if (rd == R_SP) begin
                    bad  = (adj == 10'd0);
                    word = fmt_i({{2{adj[9]}}, adj}, R_SP, 3'b000, R_SP, OPC_OPIMM);
                end else begin
                    bad  = (rd != R_ZERO) && smallz;
                    word = fmt_u({{14{ins[12]}}, ins[12], ins[6:2]}, rd);
                end
            end
            3'b100: begin
                unique case (ins[11:10])
                    2'b00, 2'b01: begin
                        bad  = ins[12];
                        word = fmt_i({1'b0, ins[10], 5'd0, ins[6:2]}, rdc, 3'b101, rdc, OPC_OPIMM);
                    end
                    2'b10: word = fmt_i(simm, rdc, 3'b111, rdc, OPC_OPIMM);
                    default: begin
                        bad = ins[12];
                        unique case (ins[6:5])
                            2'b00:   word = fmt_r(7'b0100000, rsc, rdc, 3'b000, rdc);
                            2'b01:   word = fmt_r(7'b0000000, rsc, rdc, 3'b100, rdc);
                            2'b10:   word = fmt_r(7'b0000000, rsc, rdc, 3'b110, rdc);
                            default: word = fmt_r(7'b0000000, rsc, rdc, 3'b111, rdc);
                        endcase
                    end
                endcase
            end
            3'b101: word = fmt_j({{9{ins[12]}}, joff}, R_ZERO);
            default: word = fmt_b({{4{ins[12]}}, boff}, rdc, {2'b00, ins[13]});
        endcase
    end
endmodule

// File: rtl/c16_q2.sv
// c16_q2: expands quadrant-2 words (shift left, stack load/store, jump
// register, move, add, breakpoint). Assumes quadrant 2 is selected.
module c16_q2
    import c16_pkg::*;
(
    input  logic [CW-1:2] ins,
    output logic [XW-1:0] word,
    output logic          bad
);
    rix_t       rd;
    rix_t       rs2;
    logic [7:0] loff;
    logic [7:0] soff;

    // Pull register fields and stack-relative offsets.
    always_comb begin
        rd   = ins[11:7];
        rs2  = ins[6:2];
        loff = {ins[3:2], ins[12], ins[6:4], 2'b00};
        soff = {ins[8:7], ins[12:9], 2'b00};
    end

    // Select the form by funct3, bit 12 and the zero-register cases.
    always_comb begin
        word = '0;
        bad  = 1'b0;
        unique case (ins[15:13])
            3'b000: begin
                bad  = ins[12];
                word = fmt_i({7'd0, ins[6:2]}, rd, 3'b001, rd, OPC_OPIMM);
            end
            3'b010: begin
                bad  = (rd == R_ZERO);
                word = fmt_i({4'd0, loff}, R_SP, 3'b010, rd, OPC_LOAD);
            end
            3'b100: begin
                if (!ins[12]) begin
                    if (rs2 == R_ZERO) begin
                        bad  = (rd == R_ZERO);
                        word = fmt_i(12'd0, rd, 3'b000, R_ZERO, OPC_JALR);
                    end else begin
                        word = fmt_r(7'd0, rs2, R_ZERO, 3'b000, rd);
                    end
                end else if (rs2 == R_ZERO && rd == R_ZERO) begin
                    word = WORD_EBREAK;
                end else if (rs2 == R_ZERO) begin
                    word = fmt_i(12'd0, rd, 3'b000, R_LINK, OPC_JALR);
                end else begin
                    word = fmt_r(7'd0, rs2, rd, 3'b000, rd);
                end
            end
            3'b110: word = fmt_s({4'd0, soff}, rs2, R_SP, 3'b010);
            default: bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/c16_expander.sv
// c16_expander: top level. Routes the word to the quadrant expander chosen
// by bits [1:0], passes uncompressed words through, zeroes the word of an
// illegal encoding and registers the result once.
// Assumes a synchronous active-low reset.
module c16_expander
    import c16_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cmp_word,
    output logic [XW-1:0] exp_word,
    output logic          exp_bad
);
    localparam int NQ = 3;

    logic [XW-1:0] q_word [NQ];
    logic          q_bad  [NQ];
    logic [XW-1:0] nxt_word;
    logic          nxt_bad;

    c16_q0 i_q0 (.ins(cmp_word[CW-1:2]), .word(q_word[0]), .bad(q_bad[0]));
    c16_q1 i_q1 (.ins(cmp_word[CW-1:2]), .word(q_word[1]), .bad(q_bad[1]));
    c16_q2 i_q2 (.ins(cmp_word[CW-1:2]), .word(q_word[2]), .bad(q_bad[2]));

    // Pick the quadrant result or the pass-through word.
    always_comb begin
        if (cmp_word[1:0] == 2'b11) begin
            nxt_bad  = 1'b0;
            nxt_word = {{(XW-CW){1'b0}}, cmp_word};
        end else begin
            nxt_bad  = q_bad[cmp_word[1:0]];
            nxt_word = nxt_bad ? '0 : q_word[cmp_word[1:0]];
        end
    end

    // Output register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_word <= '0;
            exp_bad  <= 1'b0;
        end else begin
            exp_word <= nxt_word;
            exp_bad  <= nxt_bad;
        end
    end
endmodule

// File: rtl/c16_expander_chk.sv
// c16_expander_chk: properties on the expander ports, bound to every instance.
module c16_expander_chk
    import c16_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] cmp_word,
    input logic [XW-1:0] exp_word,
    input logic          exp_bad
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (exp_word == '0 && !exp_bad));

    p_passthru_r13: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_word[1:0] == 2'b11 |=> (exp_word == {16'h0000, $past(cmp_word)} && !exp_bad));

    p_bad_zero_word_r12: assert property (@(posedge clk) disable iff (!rst_n)
        exp_bad |-> exp_word == '0);

    p_allzero_bad_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_word == '0 |=> exp_bad);

    p_legal_full_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_word[1:0] != 2'b11) |=> (exp_bad || exp_word[1:0] == 2'b11));
endmodule

bind c16_expander c16_expander_chk i_chk (
    .clk(clk), .rst_n(rst_n), .cmp_word(cmp_word),
    .exp_word(exp_word), .exp_bad(exp_bad)
);

// File: tb/test_c16_expander.sv
`timescale 1ns/1ps
module test_c16_expander;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cmp_word = 16'h0000;
    logic [31:0] exp_word;
    logic        exp_bad;
    int          n_chk = 0;
    int          n_err = 0;

    always #2.5 clk = ~clk;

    c16_expander i_c16_expander (.clk(clk), .rst_n(rst_n), .cmp_word(cmp_word),
                                 .exp_word(exp_word), .exp_bad(exp_bad));

    // Entry: {input, expected illegal, expected word}
    localparam int NV = 38;
    localparam logic [48:0] VEC [NV] = '{
        {16'h0040, 1'b0, 32'h0041_0413},  // R4 R3 addi x8,x2,4
        {16'h0000, 1'b1, 32'h0000_0000},  // R4 all zero illegal
        {16'h4144, 1'b0, 32'h0045_2483},  // R4 R3 lw x9,4(x10)
        {16'hC144, 1'b0, 32'h0095_2223},  // R4 sw x9,4(x10)
        {16'h12FD, 1'b0, 32'hFFF2_8293},  // R5 addi x5,x5,-1
        {16'h0005, 1'b0, 32'h0010_0013},  // R5 hint addi x0
        {16'h4515, 1'b0, 32'h0050_0513},  // R5 li x10,5
        {16'h6185, 1'b0, 32'h0000_11B7},  // R6 lui x3,1
        {16'h6181, 1'b1, 32'h0000_0000},  // R6 lui zero reserved
        {16'h7181, 1'b0, 32'hFFFE_01B7},  // R6 lui negative
        {16'h6141, 1'b0, 32'h0101_0113},  // R6 sp += 16
        {16'h6101, 1'b1, 32'h0000_0000},  // R6 sp adjust zero reserved
        {16'h7101, 1'b0, 32'hE001_0113},  // R6 sp -= 512
        {16'h800D, 1'b0, 32'h0034_5413},  // R7 srli x8,3
        {16'h840D, 1'b0, 32'h4034_5413},  // R7 srai x8,3
        {16'h900D, 1'b1, 32'h0000_0000},  // R7 shamt bit5 illegal
        {16'h98FD, 1'b0, 32'hFFF4_F493},  // R7 andi x9,-1
        {16'h8C05, 1'b0, 32'h4094_0433},  // R7 sub x8,x9
        {16'h8C65, 1'b0, 32'h0094_7433},  // R7 and x8,x9
        {16'h9C05, 1'b1, 32'h0000_0000},  // R7 64-bit form illegal
        {16'hA009, 1'b0, 32'h0020_006F},  // R8 j +2
        {16'h3FFD, 1'b0, 32'hFFFF_F0EF},  // R8 jal x1,-2
        {16'hC401, 1'b0, 32'h0004_0463},  // R9 beq x8,x0,8
        {16'hFC7D, 1'b0, 32'hFE04_1FE3},  // R9 bne x8,x0,-2
        {16'h0292, 1'b0, 32'h0042_9293},  // R10 slli x5,4
        {16'h42A2, 1'b0, 32'h0081_2283},  // R10 lw x5,8(x2)
        {16'h4022, 1'b1, 32'h0000_0000},  // R10 stack load rd0 illegal
        {16'hC41A, 1'b0, 32'h0061_2423},  // R10 sw x6,8(x2)
        {16'h8282, 1'b0, 32'h0002_8067},  // R11 jr x5
        {16'h8002, 1'b1, 32'h0000_0000},  // R11 jr x0 illegal
        {16'h829A, 1'b0, 32'h0060_02B3},  // R11 mv x5,x6
        {16'h801A, 1'b0, 32'h0060_0033},  // R11 mv hint rd0
        {16'h9002, 1'b0, 32'h0010_0073},  // R11 ebreak
        {16'h9282, 1'b0, 32'h0002_80E7},  // R11 jalr x1,x5
        {16'h929A, 1'b0, 32'h0062_82B3},  // R11 add x5,x6
        {16'h2000, 1'b1, 32'h0000_0000},  // R12 q0 float form illegal
        {16'h6002, 1'b1, 32'h0000_0000},  // R12 q2 float form illegal
        {16'hABCF, 1'b0, 32'h0000_ABCF}   // R13 pass-through
    };

    task automatic check(input string req, input logic [31:0] ew, input logic eb);
        n_chk++;
        if (exp_word !== ew || exp_bad !== eb) begin
            n_err++;
            $display("FAIL %s in=%h word=%h bad=%b expected word=%h bad=%b",
                     req, cmp_word, exp_word, exp_bad, ew, eb);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // R1: reset holds outputs at zero even with a legal word applied
        cmp_word = 16'h0040;
        repeat (3) @(negedge clk);
        check("R1", 32'h0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R4", 32'h0041_0413, 1'b0);

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            cmp_word = VEC[k][48:33];
            @(negedge clk);
            check($sformatf("vector %0d", k), VEC[k][31:0], VEC[k][32]);
        end

        // R2: output holds until the next rising edge
        @(negedge clk);
        cmp_word = 16'h4515;
        @(negedge clk);
        cmp_word = 16'h0000;
        #1;
        check("R2", 32'h0050_0513, 1'b0);
        @(negedge clk);
        check("R2", 32'h0, 1'b1);

        // R1: reset in mid-stream clears a pending illegal flag
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 32'h0, 1'b0);
        rst_n = 1'b1;
        cmp_word = 16'h9002;
        @(negedge clk);
        check("R11", 32'h0010_0073, 1'b0);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule